// File: doc/BRIEF.md
# Tristate Enable Timing Advancer

This block drives the enable strobe of an external output buffer that sits on one serial TDM output stream. It keeps its own frame position, restarted by a frame pulse, and maps that position onto the output stream using the stream's programmed channel delay and bit offset. For every position it asks the connection store for the high-impedance flag of one channel. It then raises the strobe for channels that carry data and lowers it for channels that must float. One instance serves one stream, so a switch with sixteen output streams uses sixteen instances.

External buffers switch more slowly than the serializer does. To cover that, the strobe can be moved earlier than the data by a programmable fraction of a bit. At the three lower rates the advance comes in quarter-bit steps up to one full bit. At the highest rate it comes in half-bit steps only. The advance moves both edges of every high-impedance window by the same amount. The block is clocked by a sub-bit tick clock. At rate codes 0 to 2 each data bit lasts four ticks; at rate code 3 it lasts two ticks.

The block has two states. ST_WAIT_FP holds the strobe low until a frame pulse arrives. ST_RUN drives the strobe. Three transitions connect them. T_SYNC goes from ST_WAIT_FP to ST_RUN on a frame pulse. T_RESYNC stays in ST_RUN and realigns the frame when a frame pulse arrives while running. T_DROP goes from ST_RUN to ST_WAIT_FP when the rate select changes.

Top module: `tz_adv_strobe`

## Requirements
- R1: While reset is asserted, and on the first edge after it, oe_o is 0 and the block is in ST_WAIT_FP.
- R2: oe_o stays 0 until a frame pulse is sampled. The first tick after the edge that samples fp_i high is tick 0 of a new frame.
- R3: Rate code r (0 to 3) gives a frame of 32<<r channels of 8 bits each. A bit lasts 4 ticks for r = 0, 1, 2 and 2 ticks for r = 3. The frame counter wraps after the last tick.
- R4: The output stream's channel 0, bit 0, starts (chan_dly_i*8 + bit_ofs_i) bits after frame tick 0. chan_dly_i is first masked to the channel count of the selected rate.
- R5: With zero advancement, oe_o during a tick equals the inverse of the high-impedance flag of the stream channel being output in that tick.
- R6: At rate codes 0 to 2, advancement codes 0 to 4 move both strobe edges earlier by 0, 1, 2, 3 or 4 quarter-bit ticks.
- R7: At rate code 3, advancement code 2 moves both edges earlier by half a bit (1 tick) and code 4 by a full bit (2 ticks).
- R8: Codes 5 to 7 at any rate, and codes 1 and 3 at rate code 3, give zero advancement.
- R9: look_ch_o names the channel whose flag look_hiz_i must return in the same cycle. That flag sets oe_o at the next clock edge.
- R10: A frame pulse sampled in ST_RUN restarts the frame at tick 0 on the next tick.
- R11: A change of rate_i sampled in ST_RUN forces oe_o to 0 and returns the block to ST_WAIT_FP. A frame pulse sampled on that same edge is ignored.
- R12: Advancement that reaches past the last tick of the frame wraps to channel 0 of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-bit tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_i | input | 1 | Frame pulse, one tick wide |
| rate_i | input | 2 | Rate code: 0 lowest, 3 highest |
| chan_dly_i | input | 8 | Stream channel delay in channels |
| bit_ofs_i | input | 3 | Stream bit offset in bits |
| adv_code_i | input | 3 | Strobe advancement code |
| look_ch_o | output | 8 | Channel whose high-impedance flag is needed |
| look_hiz_i | input | 1 | High-impedance flag of look_ch_o |
| oe_o | output | 1 | Buffer enable strobe, 1 = drive |

## Verification
Every input, including the flag returned for look_ch_o, acts on oe_o exactly one rising edge after it is sampled. look_ch_o itself is combinational in the same cycle. The bench changes inputs only one nanosecond after a rising edge. At each edge it advances its own frame model from the inputs that were held across that edge. It then compares oe_o one nanosecond later with the flag that its modular position arithmetic predicts. State changes are checked the same way: a rate drop shows up as oe_o at 0 on the tick after the change, and a frame pulse shows up as tick 0 on the tick after the pulse.

// File: rtl/tza_pkg.sv
`timescale 1ns/1ps
package tza_pkg;
    localparam int CH_W   = 8;
    localparam int BOFS_W = 3;
    localparam int ADV_W  = 3;
    localparam int CNT_W  = CH_W + BOFS_W + 1;
    localparam int FRM_W  = CNT_W + 1;
    localparam int BASE_CH_LOG = 5;

    typedef enum logic {
        ST_WAIT_FP = 1'b0,
        ST_RUN     = 1'b1
    } sync_state_e;

    // log2 of ticks per data bit
    function automatic int tick_shift(input logic [1:0] rate);
        return (rate == 2'd3) ? 1 : 2;
    endfunction

    function automatic logic [CH_W-1:0] chan_mask(input logic [1:0] rate);
        logic [CH_W-1:0] m;
        m = CH_W'((1 << (BASE_CH_LOG + int'(rate))) - 1);
        return m;
    endfunction

    function automatic logic [FRM_W-1:0] frame_ticks(input logic [1:0] rate);
        int sh;
        sh = BASE_CH_LOG + int'(rate) + BOFS_W + tick_shift(rate);
        return FRM_W'(1 << sh);
    endfunction
endpackage

// File: rtl/tza_adv_decode.sv
`timescale 1ns/1ps
module tza_adv_decode #(
    parameter int ADV_W = tza_pkg::ADV_W
) (
    input  logic [ADV_W-1:0] code,
    input  logic [1:0]       rate,
    output logic [2:0]       adv_ticks
);
    localparam logic [ADV_W-1:0] FULL_BIT = ADV_W'(4);
    localparam logic [ADV_W-1:0] HALF_BIT = ADV_W'(2);

    always_comb begin
        adv_ticks = 3'd0;
        if (rate == 2'd3) begin
            // half-bit steps only
            if (code == HALF_BIT)      adv_ticks = 3'd1;
            else if (code == FULL_BIT) adv_ticks = 3'd2;
        end else if (code <= FULL_BIT) begin
            adv_ticks = 3'(code);
        end
    end
endmodule

// File: rtl/tza_sync_fsm.sv
`timescale 1ns/1ps
module tza_sync_fsm #(
    parameter int CNT_W = tza_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fp_i,
    input  logic [1:0]       rate_i,
    output logic             running,
    output logic             run_nx,
    output logic [1:0]       rate_q,
    output logic [CNT_W-1:0] frm_cnt,
    output logic [CNT_W-1:0] cnt_nx
);
    import tza_pkg::*;

    localparam int FRM_W_L = CNT_W + 1;

    sync_state_e state, state_nx;
    logic [FRM_W_L-1:0] cnt_inc;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_WAIT_FP;
            frm_cnt <= '0;
            rate_q  <= 2'd0;
        end else begin
            state   <= state_nx;
            frm_cnt <= cnt_nx;
            rate_q  <= rate_i;
        end
    end

    // transitions: T_SYNC, T_RESYNC, T_DROP
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT_FP: if (fp_i) state_nx = ST_RUN;            // T_SYNC
            ST_RUN:     if (rate_i != rate_q) state_nx = ST_WAIT_FP; // T_DROP
        endcase
    end

    // outputs and frame position
    always_comb begin
        running = (state == ST_RUN);
        run_nx  = (state_nx == ST_RUN);
        cnt_inc = FRM_W_L'(frm_cnt) + FRM_W_L'(1);
        if (fp_i) begin
            cnt_nx = '0;                                          // T_SYNC / T_RESYNC
        end else if (state == ST_RUN) begin
            cnt_nx = (cnt_inc >= FRM_W_L'(frame_ticks(rate_i))) ? '0 : CNT_W'(cnt_inc);
        end else begin
            cnt_nx = frm_cnt;
        end
    end
endmodule

// File: rtl/tza_pos_map.sv
`timescale 1ns/1ps
module tza_pos_map #(
    parameter int CNT_W  = tza_pkg::CNT_W,
    parameter int CH_W   = tza_pkg::CH_W,
    parameter int BOFS_W = tza_pkg::BOFS_W
) (
    input  logic [CNT_W-1:0]  fnext,
    input  logic [1:0]        rate,
    input  logic [CH_W-1:0]   chan_dly,
    input  logic [BOFS_W-1:0] bit_ofs,
    input  logic [2:0]        adv,
    output logic [CH_W-1:0]   look_ch
);
    import tza_pkg::*;

    localparam int W = CNT_W + 1;

    logic [W-1:0] frm_len, off_bits, off_t, fn_w, pos, la;

    always_comb begin
        frm_len  = W'(frame_ticks(rate));
        off_bits = W'({chan_dly & chan_mask(rate), bit_ofs});
        off_t    = off_bits << tick_shift(rate);
        fn_w     = W'(fnext);
        // stream position of the coming tick
        if (fn_w >= off_t) pos = fn_w - off_t;
        else               pos = fn_w + frm_len - off_t;
        // look ahead by the advancement, wrapping into the next frame
        la = pos + W'(adv);
        if (la >= frm_len) la = la - frm_len;
        look_ch = CH_W'(la >> (tick_shift(rate) + BOFS_W));
    end
endmodule

// File: rtl/tz_adv_strobe.sv
`timescale 1ns/1ps
module tz_adv_strobe #(
    parameter int CH_W   = tza_pkg::CH_W,
    parameter int BOFS_W = tza_pkg::BOFS_W,
    parameter int ADV_W  = tza_pkg::ADV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fp_i,
    input  logic [1:0]        rate_i,
    input  logic [CH_W-1:0]   chan_dly_i,
    input  logic [BOFS_W-1:0] bit_ofs_i,
    input  logic [ADV_W-1:0]  adv_code_i,
    output logic [CH_W-1:0]   look_ch_o,
    input  logic              look_hiz_i,
    output logic              oe_o
);
    localparam int CNT_W = CH_W + BOFS_W + 1;

    logic             running, run_nx;
    logic [1:0]       rate_q;
    logic [CNT_W-1:0] frm_cnt, cnt_nx;
    logic [2:0]       adv_ticks;

    tza_sync_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .rate_i(rate_i),
        .running(running), .run_nx(run_nx), .rate_q(rate_q),
        .frm_cnt(frm_cnt), .cnt_nx(cnt_nx)
    );

    tza_adv_decode #(.ADV_W(ADV_W)) u_adv (
        .code(adv_code_i), .rate(rate_i), .adv_ticks(adv_ticks)
    );

    tza_pos_map #(.CNT_W(CNT_W), .CH_W(CH_W), .BOFS_W(BOFS_W)) u_map (
        .fnext(cnt_nx), .rate(rate_i), .chan_dly(chan_dly_i),
        .bit_ofs(bit_ofs_i), .adv(adv_ticks), .look_ch(look_ch_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) oe_o <= 1'b0;
        else        oe_o <= run_nx & ~look_hiz_i;
    end
endmodule

// File: rtl/tz_adv_chk.sv
`timescale 1ns/1ps
module tz_adv_chk #(
    parameter int CH_W  = tza_pkg::CH_W,
    parameter int CNT_W = tza_pkg::CNT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fp_i,
    input logic [1:0]       rate_i,
    input logic [CH_W-1:0]  look_ch_o,
    input logic             oe_o,
    input logic             running,
    input logic [1:0]       rate_q,
    input logic [CNT_W-1:0] frm_cnt
);
    AST_OE_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |-> running); // R2
    AST_FP_TICK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fp_i |=> frm_cnt == '0); // R2
    AST_RATE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && rate_i != rate_q) |=> (!running && !oe_o)); // R11
    AST_FP_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_i && !(running && rate_i != rate_q)) |=> running); // R10
    AST_CH_RANGE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (running && rate_i == rate_q && rate_i == 2'd0) |-> look_ch_o < CH_W'(32)); // R3
    AST_CH_RANGE_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (running && rate_i == rate_q && rate_i == 2'd1) |-> look_ch_o < CH_W'(64)); // R3
endmodule

bind tz_adv_strobe tz_adv_chk #(.CH_W(CH_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .rate_i(rate_i),
    .look_ch_o(look_ch_o), .oe_o(oe_o), .running(running),
    .rate_q(rate_q), .frm_cnt(frm_cnt)
);

// File: tb/test_tz_adv_strobe.sv
`timescale 1ns/1ps
module test_tz_adv_strobe;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, fp_i, look_hiz_i, oe_o;
    logic [1:0] rate_i;
    logic [7:0] chan_dly_i, look_ch_o;
    logic [2:0] bit_ofs_i, adv_code_i;
    logic [255:0] hz_tbl;

    assign look_hiz_i = hz_tbl[look_ch_o];

    tz_adv_strobe i_tz_adv_strobe (
        .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .rate_i(rate_i),
        .chan_dly_i(chan_dly_i), .bit_ofs_i(bit_ofs_i), .adv_code_i(adv_code_i),
        .look_ch_o(look_ch_o), .look_hiz_i(look_hiz_i), .oe_o(oe_o)
    );

    int n_run = 0, n_fail = 0;
    bit done = 0;
    bit m_run = 0;
    int m_f = 0;
    logic [1:0] m_rq = 2'd0;

    function automatic int tpb(input int r);
        return (r == 3) ? 2 : 4;
    endfunction
    function automatic int fr_len(input int r);
        return (32 << r) * 8 * tpb(r);
    endfunction
    function automatic int adv_of(input int code, input int r);
        if (r == 3) return (code == 2) ? 1 : (code == 4) ? 2 : 0;
        return (code <= 4) ? code : 0;
    endfunction
    function automatic bit exp_oe();
        int r, f, off, a, la;
        if (!m_run) return 1'b0;
        r   = int'(rate_i);
        f   = fr_len(r);
        off = ((int'(chan_dly_i) % (32 << r)) * 8 + int'(bit_ofs_i)) * tpb(r);
        a   = adv_of(int'(adv_code_i), r);
        la  = (((m_f - off + a) % f) + f) % f;
        return !hz_tbl[la / (8 * tpb(r))];
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s oe_o=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        if (!m_run) begin
            if (fp_i) begin m_run = 1; m_f = 0; end
        end else if (rate_i != m_rq) begin
            m_run = 0;
        end else if (fp_i) begin
            m_f = 0;
        end else begin
            m_f = (m_f + 1) % fr_len(int'(rate_i));
        end
        m_rq = rate_i;
        #1;
        check(tag, oe_o, exp_oe());
    endtask

    task automatic new_table();
        for (int i = 0; i < 8; i++) hz_tbl[i*32 +: 32] = $urandom();
    endtask

    task automatic run_cfg(input int r, input int dly, input int ofs, input int code,
                           input bit resync, input string tag);
        int n;
        rate_i = 2'(r); chan_dly_i = 8'(dly); bit_ofs_i = 3'(ofs); adv_code_i = 3'(code);
        new_table();
        tick("R11");
        fp_i = 1'b1;
        tick(tag);
        fp_i = 1'b0;
        n = fr_len(r) + fr_len(r) / 2;
        for (int i = 0; i < n; i++) begin
            if (resync && i == fr_len(r) / 3) fp_i = 1'b1;
            tick(tag);
            fp_i = 1'b0;
        end
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'd1729);
        rst_n = 1'b0; fp_i = 1'b0; rate_i = 2'd0;
        chan_dly_i = 8'd0; bit_ofs_i = 3'd0; adv_code_i = 3'd0;
        hz_tbl = '0;
        repeat (4) @(posedge clk);
        #1;
        check("R1", oe_o, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) tick("R2");

        run_cfg(0, 0, 0, 0, 0, "R5");
        run_cfg(0, 3, 5, 0, 0, "R4");
        run_cfg(1, 70, 2, 2, 0, "R3");
        run_cfg(2, 100, 7, 3, 0, "R6");
        run_cfg(0, 0, 0, 4, 0, "R12");
        run_cfg(3, 200, 1, 2, 0, "R7");
        run_cfg(3, 0, 0, 4, 0, "R7");
        run_cfg(3, 17, 4, 1, 0, "R8");
        run_cfg(2, 5, 3, 6, 0, "R8");
        run_cfg(1, 9, 6, 4, 1, "R10");
        for (int k = 0; k < 4; k++)
            run_cfg(int'($urandom_range(0, 3)), int'($urandom_range(0, 255)),
                    int'($urandom_range(0, 7)), int'($urandom_range(0, 7)), 0, "R9");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule